// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block receives stereo audio serially as a slave. It runs entirely on the incoming bit clock, samples data and word select on each rising edge, and rebuilds one left and one right sample per frame. A two-bit format input chooses between the delayed MSB-first framing (I2S, word lengths up to 24 bits) and right-justified framing, where the word ends on the last bit before the word-select change and is 16, 20 or 24 bits long. Crossing the samples into a system clock domain is left to a FIFO outside the block.

Every word leaves the block left-aligned in a 24-bit field. The MSB sits at bit 23, and bit positions the word does not fill are zero. A two's-complement sample therefore keeps its sign bit at the top without any extension logic. When both halves of a frame are complete, the pair appears on the outputs together with a one-cycle valid strobe. The outputs then hold until the next frame completes.

A three-state controller sequences the capture. SYNC discards everything after reset until word select falls (transition LOCK, to LEFT). LEFT collects the left half; a word-select edge stores the left word (transition LEFT_DONE, to RIGHT). RIGHT collects the right half; the word-select edge that opens the next left half publishes the pair and latches the format for the new frame (transition FRAME_DONE, to LEFT).

Top module: `aud_serial_rx`

## Requirements
- R1: While reset is asserted and after it is released, `frame_valid` is 0 and both sample outputs are 0 until the first complete frame.
- R2: With `fmt_sel` = 00 (I2S), the MSB is the bit sampled on the second rising bit-clock edge after a word-select change. The last bit of a half-frame is the one sampled on the edge where the new word-select level is first seen; a 24-bit word that fills a 24-bit half-frame is captured exactly.
- R3: In I2S mode a half-frame shorter than 24 bits yields its bits in the upper part of the output, with the remaining low bits zero.
- R4: In I2S mode only the first 24 bits of a half-frame are kept; later bits have no effect on the output.
- R5: With `fmt_sel` = 01, 10 or 11, the word is the last 16, 20 or 24 bits sampled before the edge on which the word-select change is seen, MSB first. It is left-aligned with zero low bits; earlier bits of the half-frame have no effect.
- R6: Bits received while word select is low form the left sample; bits received while it is high form the right sample.
- R7: `frame_valid` is a single-cycle pulse, raised after the rising edge on which word select is first seen low following a right half. The sample outputs change only together with this pulse and hold otherwise.
- R8: Half-frames received before the first falling word-select edge after reset never produce a pulse.
- R9: The format is taken at the start of each left half and applies to both halves of that frame, even if `fmt_sel` changes as the next frame begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; all logic uses its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_sel | input | 1 | Channel select: low = left, high = right; changes after falling bit-clock edges |
| ser_data | input | 1 | Serial data, MSB first |
| fmt_sel | input | 2 | 00 I2S, 01 right-justified 16, 10 right-justified 20, 11 right-justified 24 |
| left_sample | output | OUT_W | Left word, left-aligned |
| right_sample | output | OUT_W | Right word, left-aligned |
| frame_valid | output | 1 | One-cycle strobe when a new pair is on the outputs |

## Verification
In I2S mode, the closing bit of a right half and the publication of the frame fall on the same rising edge. On that edge the shift path must include the bit being sampled while the controller moves to LEFT and drives the strobe. The bench provokes this with a 24-bit word in a 24-bit half-frame whose LSB differs from its neighbours, so a missing or misplaced final bit shows up in the published value. A second collision occurs at a format switch: the old frame's right word is finalised under its own format on the same edge that latches the new one, and the bench judges it by following I2S frames with right-justified frames and the reverse.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

    typedef enum logic [1:0] {
        FMT_I2S  = 2'b00,
        FMT_RJ16 = 2'b01,
        FMT_RJ20 = 2'b10,
        FMT_RJ24 = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        ST_SYNC  = 2'b00,
        ST_LEFT  = 2'b01,
        ST_RIGHT = 2'b10
    } rx_state_e;

    // word length of a right-justified format
    function automatic int unsigned rj_len(input fmt_e f);
        case (f)
            FMT_RJ16: return 16;
            FMT_RJ20: return 20;
            default:  return 24;
        endcase
    endfunction

endpackage

// File: rtl/aud_rx_framer.sv
// Samples word select and data, keeps the bit history and counts bits per half-frame.
module aud_rx_framer #(
    parameter int SLOT_W = 32,
    localparam int CNT_W = $clog2(SLOT_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ws_i,
    input  logic              sd_i,
    output logic              edge_o,
    output logic [SLOT_W-1:0] shift_q_o,
    output logic [SLOT_W-1:0] shift_next_o,
    output logic [CNT_W-1:0]  nbits_o
);
    localparam logic [CNT_W-1:0] CNT_CAP = CNT_W'(SLOT_W - 1);

    logic              ws_q;
    logic [SLOT_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;

    assign edge_o       = ws_i ^ ws_q;
    assign shift_next_o = {sh_q[SLOT_W-2:0], sd_i};
    assign shift_q_o    = sh_q;
    // bits of the closing half, counting the one sampled on this edge
    assign nbits_o      = cnt_q + CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ws_q  <= 1'b0;
            sh_q  <= '0;
            cnt_q <= '0;
        end else begin
            ws_q <= ws_i;
            sh_q <= shift_next_o;
            if (edge_o) begin
                cnt_q <= '0;
            end else if (cnt_q < CNT_CAP) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/aud_rx_align.sv
// Picks the word out of the bit history for the active format and left-aligns it.
module aud_rx_align
    import aud_rx_pkg::*;
#(
    parameter int SLOT_W = 32,
    parameter int OUT_W  = 24,
    localparam int CNT_W = $clog2(SLOT_W + 1)
) (
    input  fmt_e              fmt_i,
    input  logic [SLOT_W-1:0] shift_q_i,
    input  logic [SLOT_W-1:0] shift_next_i,
    input  logic [CNT_W-1:0]  nbits_i,
    output logic [OUT_W-1:0]  word_o
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(SLOT_W);

    logic [SLOT_W-1:0] src;
    logic [CNT_W-1:0]  len;
    logic [CNT_W-1:0]  sh_amt;
    logic [SLOT_W-1:0] aligned;

    always_comb begin
        src = shift_next_i;
        len = nbits_i;
        unique case (fmt_i)
            FMT_I2S: begin
                // delayed framing: the bit on the edge itself closes the word
                src = shift_next_i;
                len = nbits_i;
            end
            FMT_RJ16, FMT_RJ20, FMT_RJ24: begin
                // word ends one bit before the edge
                src = shift_q_i;
                len = CNT_W'(rj_len(fmt_i));
            end
        endcase
        sh_amt  = FULL - len;
        aligned = src << sh_amt;
        word_o  = aligned[SLOT_W-1 -: OUT_W];
    end

endmodule

// File: rtl/aud_rx_fsm.sv
// Frame controller: locks to the first left half, stores the left word, publishes the pair.
module aud_rx_fsm
    import aud_rx_pkg::*;
#(
    parameter int OUT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_i,
    input  logic             ws_i,
    input  fmt_e             fmt_i,
    input  logic [OUT_W-1:0] word_i,
    output fmt_e             fmt_q_o,
    output logic [OUT_W-1:0] left_o,
    output logic [OUT_W-1:0] right_o,
    output logic             valid_o
);
    rx_state_e        state_q;
    rx_state_e        state_d;
    logic [OUT_W-1:0] left_hold;
    logic             left_start;

    assign left_start = edge_i && !ws_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SYNC;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SYNC:  if (left_start) state_d = ST_LEFT;   // LOCK
            ST_LEFT:  if (edge_i)     state_d = ST_RIGHT;  // LEFT_DONE
            ST_RIGHT: if (edge_i)     state_d = ST_LEFT;   // FRAME_DONE
            default:  state_d = ST_SYNC;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_q_o   <= FMT_I2S;
            left_hold <= '0;
            left_o    <= '0;
            right_o   <= '0;
            valid_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (left_start && state_q != ST_LEFT) begin
                fmt_q_o <= fmt_i;
            end
            if (state_q == ST_LEFT && edge_i) begin
                left_hold <= word_i;
            end
            if (state_q == ST_RIGHT && edge_i) begin
                left_o  <= left_hold;
                right_o <= word_i;
                valid_o <= 1'b1;
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R7

    AST_VALID_AT_LEFT_START: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($past(edge_i) && !$past(ws_i))); // R7

    AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(left_o) && $stable(right_o))); // R7

    AST_SYNC_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SYNC) |=> !valid_o); // R8

    AST_RJ16_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_SYNC && edge_i && fmt_q_o == FMT_RJ16) |-> (word_i[OUT_W-17:0] == '0)); // R5

endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
    import aud_rx_pkg::*;
#(
    parameter int SLOT_W = 32,
    parameter int OUT_W  = 24
) (
    input  logic             bit_clk,
    input  logic             rst_n,
    input  logic             word_sel,
    input  logic             ser_data,
    input  logic [1:0]       fmt_sel,
    output logic [OUT_W-1:0] left_sample,
    output logic [OUT_W-1:0] right_sample,
    output logic             frame_valid
);
    localparam int CNT_W = $clog2(SLOT_W + 1);

    logic              ws_edge;
    logic [SLOT_W-1:0] hist_q;
    logic [SLOT_W-1:0] hist_next;
    logic [CNT_W-1:0]  nbits;
    logic [OUT_W-1:0]  word;
    fmt_e              frame_fmt;

    aud_rx_framer #(.SLOT_W(SLOT_W)) u_framer (
        .clk          (bit_clk),
        .rst_n        (rst_n),
        .ws_i         (word_sel),
        .sd_i         (ser_data),
        .edge_o       (ws_edge),
        .shift_q_o    (hist_q),
        .shift_next_o (hist_next),
        .nbits_o      (nbits)
    );

    aud_rx_align #(.SLOT_W(SLOT_W), .OUT_W(OUT_W)) u_align (
        .fmt_i        (frame_fmt),
        .shift_q_i    (hist_q),
        .shift_next_i (hist_next),
        .nbits_i      (nbits),
        .word_o       (word)
    );

    aud_rx_fsm #(.OUT_W(OUT_W)) u_fsm (
        .clk     (bit_clk),
        .rst_n   (rst_n),
        .edge_i  (ws_edge),
        .ws_i    (word_sel),
        .fmt_i   (fmt_e'(fmt_sel)),
        .word_i  (word),
        .fmt_q_o (frame_fmt),
        .left_o  (left_sample),
        .right_o (right_sample),
        .valid_o (frame_valid)
    );

endmodule

// File: tb/aud_serial_rx_tb.sv
module aud_serial_rx_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [23:0] l;
        logic [23:0] r;
        string       tag;
    } exp_t;

    logic        bit_clk = 1'b0;
    logic        rst_n   = 1'b0;
    logic        word_sel = 1'b0;
    logic        ser_data = 1'b0;
    logic [1:0]  fmt_sel = 2'b00;
    logic [23:0] left_sample;
    logic [23:0] right_sample;
    logic        frame_valid;

    int   n_checks = 0;
    int   n_fail   = 0;
    int   n_valid  = 0;
    int   n_pushed = 0;
    exp_t exp_q[$];
    bit   prev_bit = 1'b0;
    bit   last_i2s = 1'b0;

    aud_serial_rx u_dut (
        .bit_clk      (bit_clk),
        .rst_n        (rst_n),
        .word_sel     (word_sel),
        .ser_data     (ser_data),
        .fmt_sel      (fmt_sel),
        .left_sample  (left_sample),
        .right_sample (right_sample),
        .frame_valid  (frame_valid)
    );

    always #(CLK_PERIOD/2) bit_clk = ~bit_clk;

    task automatic check(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    // expected left-aligned word from a half-frame value of slen bits
    function automatic logic [23:0] exp_word(input logic [31:0] v, input int slen, input logic [1:0] f);
        logic [31:0] t;
        int w;
        if (f == 2'b00) begin
            if (slen >= 24) t = v >> (slen - 24);
            else            t = v << (24 - slen);
        end else begin
            w = (f == 2'b01) ? 16 : (f == 2'b10) ? 20 : 24;
            t = (v & ((32'h1 << w) - 32'h1)) << (24 - w);
        end
        return t[23:0];
    endfunction

    // one half-frame; I2S bits go out one clock late
    task automatic drive_half(input bit ch, input logic [31:0] v, input int slen,
                              input logic [1:0] f, input bit first);
        bit cur;
        for (int i = 0; i < slen; i++) begin
            @(negedge bit_clk);
            word_sel = ch;
            if (first && i == 0) fmt_sel = f;
            cur = v[slen-1-i];
            if (f == 2'b00)                    ser_data = prev_bit;
            else if (first && i == 0 && last_i2s) ser_data = prev_bit;
            else                               ser_data = cur;
            prev_bit = cur;
        end
    endtask

    task automatic send_frame(input logic [1:0] f, input int slen, input logic [31:0] lv,
                              input logic [31:0] rv, input string tag);
        exp_t e;
        e.l = exp_word(lv, slen, f);
        e.r = exp_word(rv, slen, f);
        e.tag = tag;
        exp_q.push_back(e);
        n_pushed++;
        drive_half(1'b0, lv, slen, f, 1'b1);
        drive_half(1'b1, rv, slen, f, 1'b0);
        last_i2s = (f == 2'b00);
    endtask

    // scoreboard monitor
    always @(negedge bit_clk) begin
        if (rst_n && frame_valid) begin
            exp_t e;
            n_valid++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected frame_valid", {left_sample, right_sample}, 48'h0);
            end else begin
                e = exp_q.pop_front();
                check(left_sample == e.l, {e.tag, " R6 left"}, {24'h0, left_sample}, {24'h0, e.l});
                check(right_sample == e.r, {e.tag, " R6 right"}, {24'h0, right_sample}, {24'h0, e.r});
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        check(1'b0, "watchdog expired", 48'h0, 48'h1);
        summary();
        $finish;
    end

    initial begin
        logic [23:0] hold_l;
        logic [23:0] hold_r;
        bit saw_valid;
        repeat (4) @(negedge bit_clk);
        check(frame_valid == 1'b0 && left_sample == '0 && right_sample == '0,
              "R1 reset state", {left_sample, right_sample}, 48'h0);
        rst_n = 1'b1;
        @(negedge bit_clk);
        check(frame_valid == 1'b0 && left_sample == '0 && right_sample == '0,
              "R1 after release", {left_sample, right_sample}, 48'h0);

        // R8: partial halves before lock
        drive_half(1'b0, 32'h0000_001B, 5, 2'b00, 1'b0);
        drive_half(1'b1, 32'h0000_0055, 7, 2'b00, 1'b0);

        send_frame(2'b00, 32, 32'hA5C3_E100, 32'h5A3C_1E00, "R2 i2s32");
        send_frame(2'b00, 24, 32'h0080_0001, 32'h007F_FFFE, "R2 i2s24 edge-bit");
        send_frame(2'b00, 16, 32'h0000_BEEF, 32'h0000_1234, "R3 i2s16");
        send_frame(2'b00, 32, 32'hF0E1_D2C3, 32'h0F1E_2D3C, "R4 i2s tail ignored");
        send_frame(2'b01, 32, 32'hFFFF_8001, 32'hAAAA_7FFE, "R5 R9 rj16");
        send_frame(2'b10, 32, 32'hFFF9_2345, 32'h0006_789A, "R5 rj20");
        send_frame(2'b11, 32, 32'hFFC0_FFEE, 32'h0012_3456, "R5 rj24");
        send_frame(2'b11, 24, 32'h0081_2345, 32'h0000_ABCD, "R5 rj24 tight");
        send_frame(2'b00, 32, 32'h1357_9B00, 32'h2468_AC00, "R9 back to i2s");

        // closing edge for the last frame
        @(negedge bit_clk);
        word_sel = 1'b0;
        ser_data = prev_bit;
        repeat (4) @(negedge bit_clk);

        check(n_valid == n_pushed && exp_q.size() == 0, "R8 frame count",
              48'(n_valid), 48'(n_pushed));

        // R7: outputs hold with no word-select edge
        hold_l = left_sample;
        hold_r = right_sample;
        saw_valid = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(negedge bit_clk);
            ser_data = k[0];
            if (frame_valid) saw_valid = 1'b1;
        end
        check(!saw_valid && left_sample == hold_l && right_sample == hold_r,
              "R7 hold", {left_sample, right_sample}, {hold_l, hold_r});

        summary();
        $finish;
    end

endmodule